// File: doc/BRIEF.md
# Audio Serial Clock Master Divider

This block produces the serial-port clocks for a stereo audio converter that acts as clock master. It takes the master clock as its only clock. A two-bit ratio code tells it how many master-clock cycles make one sample period, and a band input marks a double-speed sample rate. From these it derives a bit clock at 64 times the sample rate and a frame (left/right) clock at the sample rate. It also drives two single-cycle strobes, so a serializer in the master-clock domain can shift data on bit-clock falling edges and detect word boundaries without a second clock domain.

The ratio code is not monotonic. Three ratios exist (256x, 384x and 512x), so the bit clock is the master clock divided by 4, 6 or 8. When the code is not legal for the chosen band, the block keeps every clock quiet and raises an error flag. Any change of the code, the band or the power-down input clears both dividers in one cycle. Both clocks then restart from a known low phase, so no shortened pulse ever reaches the converter. Power-down and reset hold everything low.

Top module: `audio_clkgen`

## Requirements
- R1: In the normal band (band_dbl_i=0) ratio code 2'b00 selects 256x (bit clock = master clock / 4), 2'b01 selects 512x (/8) and 2'b10 selects 384x (/6); in the double-speed band only 2'b00 is legal, giving /4.
- R2: Code 2'b11 in either band, or any code other than 2'b00 with band_dbl_i=1, is illegal: while it is applied and power-down is low, ratio_err_o is 1 from the first clock edge and bclk_o, lrclk_o and both strobes stay 0.
- R3: With a legal setting of divisor D, bclk_o is low for the first D/2 edges after a restart (sample index k = 0 at the clearing edge: low when k mod D < D/2) and high for the next D/2, repeating with period D.
- R4: lrclk_o starts low after a restart and toggles on every 32nd falling edge of bclk_o, giving 64 bit clocks per frame.
- R5: bit_stb_o is high for exactly one master-clock cycle in each cycle where bclk_o has just fallen, and at no other time.
- R6: frame_stb_o is high for exactly one cycle each time lrclk_o toggles through counting, and not when a restart clears lrclk_o.
- R7: A change of any of {pwr_dn_i, band_dbl_i, ratio_sel_i} seen at a clock edge clears both dividers at that edge, forcing bclk_o, lrclk_o and both strobes to 0; counting resumes from the following edge.
- R8: While pwr_dn_i is 1, every output, ratio_err_o included, is 0 and the dividers stay cleared.
- R9: During reset every output is 0, and reset behaves as power-down, so the first setting after reset begins with a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_i | input | 1 | Power-down, active high |
| band_dbl_i | input | 1 | 1 = double-speed sample-rate band |
| ratio_sel_i | input | 2 | Master-clock ratio code |
| bclk_o | output | 1 | Bit clock, 64x sample rate |
| lrclk_o | output | 1 | Frame clock, 1x sample rate |
| bit_stb_o | output | 1 | One-cycle strobe on each bit-clock falling edge |
| frame_stb_o | output | 1 | One-cycle strobe on each frame-clock edge |
| ratio_err_o | output | 1 | Illegal ratio/band combination |

## Verification
On every 32nd bit period the bit-fall strobe and the frame strobe fire in the same cycle, and the frame clock changes on the edge where the bit clock falls. A restart can also land in that cycle and must suppress all three. Directed runs long enough for several frame toggles show the coincident strobes. Random run lengths then cut settings off at arbitrary phases, including strobe cycles. Every sample is compared with a bench model indexed by cycles since the clearing edge, so a strobe that fires late, fires twice or survives a restart is caught.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    SEL_R256 = 2'b00,
    SEL_R512 = 2'b01,
    SEL_R384 = 2'b10,
    SEL_BAD  = 2'b11
  } ratio_sel_e;

  typedef struct packed {
    logic       pdn;
    logic       dbl;
    logic [1:0] sel;
  } clk_cfg_t;

  localparam int RATIO_LO  = 256;
  localparam int RATIO_MID = 384;
  localparam int RATIO_HI  = 512;

  // Reset value: looks like power-down so the first real setting restarts
  localparam clk_cfg_t CFG_RST = '{pdn: 1'b1, dbl: 1'b0, sel: 2'b00};

endpackage

// File: rtl/clkgen_ratio_dec.sv
module clkgen_ratio_dec
  import clkgen_pkg::*;
#(
  parameter int BCLK_PER_FS = 64,
  parameter int CNT_W       = 3
) (
  input  logic [1:0]       sel_i,
  input  logic             dbl_i,
  output logic             legal_o,
  output logic [CNT_W-1:0] half_o
);

  localparam int HALF_LO  = RATIO_LO  / BCLK_PER_FS / 2;
  localparam int HALF_MID = RATIO_MID / BCLK_PER_FS / 2;
  localparam int HALF_HI  = RATIO_HI  / BCLK_PER_FS / 2;

  ratio_sel_e code;
  assign code = ratio_sel_e'(sel_i);

  always_comb begin
    legal_o = 1'b0;
    half_o  = '0;
    unique case (code)
      SEL_R256: begin legal_o = 1'b1;   half_o = CNT_W'(HALF_LO);  end
      SEL_R512: begin legal_o = !dbl_i; half_o = CNT_W'(HALF_HI);  end
      SEL_R384: begin legal_o = !dbl_i; half_o = CNT_W'(HALF_MID); end
      SEL_BAD:  begin legal_o = 1'b0;   half_o = '0;               end
      default:  begin legal_o = 1'b0;   half_o = '0;               end
    endcase
  end

  always_comb begin
    if (legal_o) assert (half_o != '0) else $error("p_half_nonzero_r1");
  end

endmodule

// File: rtl/clkgen_bclk_div.sv
module clkgen_bclk_div #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             bclk_o,
  output logic             fall_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W:0]   last;
  logic             at_last;

  assign last    = {half_i, 1'b0} - 1'b1;
  assign at_last = ({1'b0, cnt_q} == last);
  assign cnt_nxt = at_last ? '0 : cnt_q + 1'b1;
  assign wrap_o  = at_last && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
      fall_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      bclk_o <= (cnt_nxt >= half_i);  // low half first, then high half
      fall_o <= at_last;
    end
  end

  p_fall_marks_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!bclk_o && $past(bclk_o)));

  p_edge_has_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bclk_o && $past(bclk_o) && !$past(clear_i)) |-> fall_o);

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> ({1'b0, cnt_q} <= last));

endmodule

// File: rtl/clkgen_frame_div.sv
module clkgen_frame_div #(
  parameter int HALF_FRAME = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic lrclk_o,
  output logic fstb_o
);

  localparam int FR_W = (HALF_FRAME > 1) ? $clog2(HALF_FRAME) : 1;
  localparam logic [FR_W-1:0] FR_LAST = FR_W'(HALF_FRAME - 1);

  logic [FR_W-1:0] cnt_q;
  logic            turn;

  assign turn = step_i && (cnt_q == FR_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lrclk_o <= 1'b0;
      fstb_o  <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      lrclk_o <= 1'b0;
      fstb_o  <= 1'b0;
    end else begin
      fstb_o <= turn;
      if (step_i) begin
        cnt_q   <= turn ? '0 : cnt_q + 1'b1;
        lrclk_o <= lrclk_o ^ turn;
      end
    end
  end

  p_fstb_on_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fstb_o |-> (lrclk_o != $past(lrclk_o)));

  p_lr_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(lrclk_o));

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import clkgen_pkg::*;
#(
  parameter int BCLK_PER_FS = 64,
  parameter int MAX_RATIO   = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_dn_i,
  input  logic       band_dbl_i,
  input  logic [1:0] ratio_sel_i,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       bit_stb_o,
  output logic       frame_stb_o,
  output logic       ratio_err_o
);

  localparam int MAX_DIV    = MAX_RATIO / BCLK_PER_FS;
  localparam int CNT_W      = $clog2(MAX_DIV);
  localparam int HALF_FRAME = BCLK_PER_FS / 2;

  clk_cfg_t         cfg_in, cfg_q;
  logic             legal;
  logic [CNT_W-1:0] half;
  logic             quiet;
  logic             wrap;

  assign cfg_in = '{pdn: pwr_dn_i, dbl: band_dbl_i, sel: ratio_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= CFG_RST;
      ratio_err_o <= 1'b0;
    end else begin
      cfg_q       <= cfg_in;
      ratio_err_o <= !pwr_dn_i && !legal;
    end
  end

  // Any setting change clears both dividers for one edge
  assign quiet = pwr_dn_i || !legal || (cfg_in != cfg_q);

  clkgen_ratio_dec #(.BCLK_PER_FS(BCLK_PER_FS), .CNT_W(CNT_W)) u_dec (
    .sel_i   (ratio_sel_i),
    .dbl_i   (band_dbl_i),
    .legal_o (legal),
    .half_o  (half)
  );

  clkgen_bclk_div #(.CNT_W(CNT_W)) u_bdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (quiet),
    .half_i  (half),
    .bclk_o  (bclk_o),
    .fall_o  (bit_stb_o),
    .wrap_o  (wrap)
  );

  clkgen_frame_div #(.HALF_FRAME(HALF_FRAME)) u_fdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (quiet),
    .step_i  (wrap),
    .lrclk_o (lrclk_o),
    .fstb_o  (frame_stb_o)
  );

  p_restart_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> (!bclk_o && !lrclk_o && !bit_stb_o && !frame_stb_o));

  p_pdn_all_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> (!ratio_err_o && !bclk_o && !lrclk_o && !bit_stb_o && !frame_stb_o));

  p_err_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_o |-> (!bclk_o && !lrclk_o && !bit_stb_o && !frame_stb_o));

  p_lr_moves_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrclk_o && !$past(lrclk_o)) |-> (bit_stb_o && frame_stb_o));

endmodule

// File: tb/sim_audio_clkgen.sv
`timescale 1ns/1ps
module sim_audio_clkgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn = 1'b0;
  logic       dbl = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       bclk, lrclk, bstb, fstb, err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  audio_clkgen u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwr_dn_i    (pdn),
    .band_dbl_i  (dbl),
    .ratio_sel_i (sel),
    .bclk_o      (bclk),
    .lrclk_o     (lrclk),
    .bit_stb_o   (bstb),
    .frame_stb_o (fstb),
    .ratio_err_o (err)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit is_legal(input bit p, input bit d, input bit [1:0] s);
    return !p && (s != 2'b11) && !(d && s != 2'b00);
  endfunction

  // R1: 00 -> /4, 01 -> /8, 10 -> /6
  function automatic int divisor(input bit [1:0] s);
    return (s == 2'b00) ? 4 : (s == 2'b01) ? 8 : 6;
  endfunction

  // Apply a setting at a falling edge, then compare len samples; k = 0 is the clearing edge
  task automatic run_cfg(input bit p, input bit d, input bit [1:0] s, input int len);
    bit ok;
    int dv;
    pdn = p; dbl = d; sel = s;
    ok = is_legal(p, d, s);
    dv = divisor(s);
    for (int k = 0; k < len; k++) begin
      bit eb, ef, el, es, ee;
      string rq;
      @(negedge clk);
      ee = !p && !ok;
      if (ok) begin
        eb = (k % dv) >= dv / 2;
        ef = (k > 0) && (k % dv == 0);
        el = ((k / dv) / 32) % 2 == 1;
        es = (k > 0) && (k % (32 * dv) == 0);
      end else begin
        eb = 0; ef = 0; el = 0; es = 0;
      end
      if (p)            rq = "R8";
      else if (!ok)     rq = "R2";
      else if (k == 0)  rq = "R7";
      else              rq = "";
      chk(rq == "" ? "R1,R3" : rq, "bclk",  bclk,  eb);
      chk(rq == "" ? "R5"    : rq, "bstb",  bstb,  ef);
      chk(rq == "" ? "R4"    : rq, "lrclk", lrclk, el);
      chk(rq == "" ? "R6"    : rq, "fstb",  fstb,  es);
      chk(p ? "R8" : "R2",         "err",   err,   ee);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit cp, cd;
    bit [1:0] cs;
    void'($urandom(32'h0c1c_a5e1));
    repeat (3) @(negedge clk);
    chk("R9", "bclk",  bclk,  1'b0);
    chk("R9", "lrclk", lrclk, 1'b0);
    chk("R9", "bstb",  bstb,  1'b0);
    chk("R9", "fstb",  fstb,  1'b0);
    chk("R9", "err",   err,   1'b0);
    rst_n = 1'b1;
    // first setting equals the held inputs: reset must still force a restart
    run_cfg(0, 0, 2'b00, 600);
    run_cfg(0, 0, 2'b01, 1100);
    run_cfg(0, 0, 2'b10, 900);
    run_cfg(0, 1, 2'b00, 400);
    run_cfg(0, 1, 2'b01, 40);
    run_cfg(0, 1, 2'b10, 40);
    run_cfg(0, 0, 2'b11, 40);
    run_cfg(0, 0, 2'b10, 300);
    run_cfg(1, 0, 2'b10, 50);
    run_cfg(0, 0, 2'b10, 300);
    // change exactly on a coincident bit/frame strobe cycle of /4
    run_cfg(0, 0, 2'b00, 128);
    run_cfg(0, 0, 2'b01, 64);
    cp = 0; cd = 0; cs = 2'b01;
    for (int i = 0; i < 30; i++) begin
      bit np, nd;
      bit [1:0] ns;
      do begin
        np = ($urandom % 8) == 0;
        nd = ($urandom % 4) == 0;
        ns = 2'($urandom % 4);
      end while ({np, nd, ns} == {cp, cd, cs});
      run_cfg(np, nd, ns, 1 + int'($urandom % 700));
      cp = np; cd = nd; cs = ns;
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule